// File: doc/BRIEF.md
# Buffered Auto-Reload Countdown Channel

This block is one down-counting timer channel. Software writes a count buffer and a compare buffer. Both are held apart from the live counter and reach it only through a reload. The channel is steered by three bits it picks out of a control word shared by several channels: start, manual update and auto-reload. Start and manual update act on their rising and falling edges, not on their levels. Auto-reload is read as a level.

A rising manual-update bit copies the count buffer into the live counter. A rising start bit lets the channel count, and a falling start bit halts it. While the channel counts, every clock cycle with the tick enable high lowers the live count by one. A tick that finds the count at zero is the expiry tick. In that same cycle the channel raises a one-cycle expiry pulse. With auto-reload set, it then reloads from the count buffer and keeps running. With auto-reload clear, it stops and asks the shared control register to clear its start bit. A count buffer value of N therefore gives a period of N+1 ticks.

A parameter gives the channel's position in the shared control word, which sets the bit positions it decodes. The last channel position has no compare buffer.

Top module: `cdtc_channel`

## Requirements
- R1: After reset, the live count, both buffers, the expiry pulse and the start-clear request are all zero, and the channel is stopped.
- R2: A buffer write with buf_sel=0 stores buf_wdata in the count buffer, and one with buf_sel=1 stores it in the compare buffer. Either value can be read back from the clock edge after the write. A buffer write never changes the live count.
- R3: A 0→1 change of the manual-update bit loads the count buffer into the live count at the next clock edge. Holding the bit high causes no further loads.
- R4: A 0→1 change of the start bit starts the channel from the next cycle. The tick in the cycle of that change is not counted. While the channel runs, each tick with a nonzero count lowers the count by one. While it is stopped, ticks leave the count unchanged.
- R5: A 1→0 change of the start bit halts the channel at the next edge. A tick in that same cycle is ignored.
- R6: expire_pulse is high exactly in a cycle where the channel runs, tick_en is high, the live count is zero, and neither a manual-update rising edge nor a start falling edge is present.
- R7: On expiry with the auto-reload bit set, the live count is loaded from the count buffer and the channel keeps running.
- R8: On expiry with the auto-reload bit clear, start_clr_req is high in the expiry cycle, the channel stops, and the live count stays at zero.
- R9: When a manual-update edge and a start edge arrive in the same cycle, the load takes place first and counting begins from the loaded value.
- R10: Control bit positions depend on CHAN_IDX. For channel 0, start is bit 0, manual update is bit 1 and auto-reload is bit 3. For a middle channel i, the base is 4i+4, and start, manual update and auto-reload sit at base+0, base+1 and base+3. The last channel uses base+0, base+1 and base+2; for index 4 these are bits 20, 21 and 22. All other bits of the word have no effect on the channel.
- R11: In the last channel position there is no compare buffer. Writes with buf_sel=1 are ignored there, and cmp_buf_q reads zero.
- R12: When a manual-update edge and a tick arrive in the same cycle while the channel runs, the load wins. There is no decrement and no expiry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable strobe, one count per high cycle |
| ctrl_word | input | CTRL_W | Shared control word holding every channel's control bits |
| buf_we | input | 1 | Buffer write strobe |
| buf_sel | input | 1 | Buffer select: 0 count buffer, 1 compare buffer |
| buf_wdata | input | CNT_W | Buffer write data |
| live_cnt | output | CNT_W | Live counter value |
| cnt_buf_q | output | CNT_W | Count buffer read-back |
| cmp_buf_q | output | CNT_W | Compare buffer read-back (zero when absent) |
| expire_pulse | output | 1 | One-cycle expiry indication, combinational with the expiry tick |
| start_clr_req | output | 1 | Request to clear this channel's start bit, same cycle as expiry |

## Verification
expire_pulse and start_clr_req follow the inputs of the current cycle through logic alone. The bench therefore samples them one time unit after it drives new inputs at the falling edge, before the rising edge that consumes them. The live count, the run state and both buffers change at the rising edge after the stimulus: one register stage for a load, a decrement, a buffer write or a start/halt. The bench compares them at the next falling edge, against a model it advances once for each driven cycle. A start edge takes effect one cycle late because the start bit passes through the edge-detect register, so the first counted tick is in the cycle after the edge.

// File: rtl/cdtc_pkg.sv
package cdtc_pkg;

  // Control levels picked out of the shared control word for one channel.
  typedef struct packed {
    logic start;
    logic upd;
    logic autoreload;
  } chan_lvl_t;

  // Edge events derived from the control levels.
  typedef struct packed {
    logic upd_rise;
    logic start_rise;
    logic start_fall;
  } chan_evt_t;

  // Lowest control bit owned by a channel; channel 0 is packed at the bottom.
  function automatic int unsigned ctl_base(input int unsigned idx);
    return (idx == 0) ? 0 : (4 * idx + 4);
  endfunction

  // The last channel has no invert bit, so its auto-reload moves down by one.
  function automatic int unsigned ar_pos(input int unsigned idx, input int unsigned num);
    return ctl_base(idx) + ((idx == num - 1) ? 2 : 3);
  endfunction

  function automatic bit has_cmp(input int unsigned idx, input int unsigned num);
    return idx != (num - 1);
  endfunction

endpackage

// File: rtl/cdtc_ctl_decode.sv
module cdtc_ctl_decode
  import cdtc_pkg::*;
#(
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned CHAN_IDX = 0,
  parameter int unsigned NUM_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  output chan_lvl_t         lvl,
  output chan_evt_t         evt
);

  localparam int unsigned START_POS = ctl_base(CHAN_IDX);
  localparam int unsigned UPD_POS   = START_POS + 1;
  localparam int unsigned AR_POS    = ar_pos(CHAN_IDX, NUM_CHAN);

  logic start_prev_q;
  logic upd_prev_q;

  always_comb begin
    lvl.start      = ctrl_word[START_POS];
    lvl.upd        = ctrl_word[UPD_POS];
    lvl.autoreload = ctrl_word[AR_POS];
  end

  // Previous levels, so that start and update act on edges only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prev_q <= 1'b0;
      upd_prev_q   <= 1'b0;
    end else begin
      start_prev_q <= lvl.start;
      upd_prev_q   <= lvl.upd;
    end
  end

  always_comb begin
    evt.upd_rise   = lvl.upd & ~upd_prev_q;
    evt.start_rise = lvl.start & ~start_prev_q;
    evt.start_fall = ~lvl.start & start_prev_q;
  end

endmodule

// File: rtl/cdtc_buffers.sv
module cdtc_buffers #(
  parameter int unsigned CNT_W   = 16,
  parameter bit          HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] cmp_buf
);

  logic cnt_wr;
  assign cnt_wr = wr_en & ~wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_buf <= '0;
    else if (cnt_wr) cnt_buf <= wr_data;
  end

  generate
    if (HAS_CMP) begin : g_cmp
      logic             cmp_wr;
      logic [CNT_W-1:0] cmp_q;
      assign cmp_wr = wr_en & wr_sel;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wr_data;
      end
      assign cmp_buf = cmp_q;
    end else begin : g_no_cmp
      assign cmp_buf = '0;
    end
  endgenerate

endmodule

// File: rtl/cdtc_down_core.sv
module cdtc_down_core
  import cdtc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  chan_lvl_t        lvl,
  input  chan_evt_t        evt,
  input  logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire,
  output logic             stop_req
);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic             tick_live;
  logic             at_zero;
  logic             dec_step;
  logic             reload;
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;

  // A tick counts only while running and not overridden by a load or halt.
  assign tick_live = run_q & tick_en & ~evt.upd_rise & ~evt.start_fall;
  assign at_zero   = (cnt_q == '0);
  assign expire    = tick_live & at_zero;
  assign dec_step  = tick_live & ~at_zero;
  assign reload    = expire & lvl.autoreload;
  assign stop_req  = expire & ~lvl.autoreload;

  always_comb begin
    cnt_d = cnt_q;
    if (evt.upd_rise)  cnt_d = cnt_buf;
    else if (reload)   cnt_d = cnt_buf;
    else if (dec_step) cnt_d = step_down(cnt_q);
  end

  always_comb begin
    run_d = run_q;
    if (evt.start_fall)      run_d = 1'b0;
    else if (evt.start_rise) run_d = 1'b1;
    else if (stop_req)       run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/cdtc_channel.sv
module cdtc_channel
  import cdtc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned NUM_CHAN = 5,
  parameter int unsigned CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              buf_we,
  input  logic              buf_sel,
  input  logic [CNT_W-1:0]  buf_wdata,
  output logic [CNT_W-1:0]  live_cnt,
  output logic [CNT_W-1:0]  cnt_buf_q,
  output logic [CNT_W-1:0]  cmp_buf_q,
  output logic              expire_pulse,
  output logic              start_clr_req
);

  localparam bit CMP_PRESENT = has_cmp(CHAN_IDX, NUM_CHAN);

  chan_lvl_t lvl_w;
  chan_evt_t evt_w;

  // Named internal events, visible to the bound checker.
  logic run_w;
  logic upd_rise_w;
  logic start_fall_w;
  logic ar_w;

  cdtc_ctl_decode #(
    .CTRL_W  (CTRL_W),
    .CHAN_IDX(CHAN_IDX),
    .NUM_CHAN(NUM_CHAN)
  ) decode_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_word(ctrl_word),
    .lvl      (lvl_w),
    .evt      (evt_w)
  );

  cdtc_buffers #(
    .CNT_W  (CNT_W),
    .HAS_CMP(CMP_PRESENT)
  ) bufs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (buf_we),
    .wr_sel (buf_sel),
    .wr_data(buf_wdata),
    .cnt_buf(cnt_buf_q),
    .cmp_buf(cmp_buf_q)
  );

  cdtc_down_core #(
    .CNT_W(CNT_W)
  ) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .lvl     (lvl_w),
    .evt     (evt_w),
    .cnt_buf (cnt_buf_q),
    .cnt_q   (live_cnt),
    .run_q   (run_w),
    .expire  (expire_pulse),
    .stop_req(start_clr_req)
  );

  assign upd_rise_w   = evt_w.upd_rise;
  assign start_fall_w = evt_w.start_fall;
  assign ar_w         = lvl_w.autoreload;

endmodule

// File: rtl/cdtc_channel_chk.sv
module cdtc_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [CNT_W-1:0] live_cnt,
  input logic [CNT_W-1:0] cnt_buf_q,
  input logic             expire_pulse,
  input logic             start_clr_req,
  input logic             run_q,
  input logic             upd_rise,
  input logic             start_fall,
  input logic             ar
);

  // R6
  expire_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> (tick_en && run_q && live_cnt == '0));

  // R8
  clr_needs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr_req |-> (expire_pulse && !ar));

  // R8
  clr_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr_req |=> !run_q);

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_pulse && ar) |=> (run_q && live_cnt == $past(cnt_buf_q)));

  // R3
  upd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise |=> (live_cnt == $past(cnt_buf_q)));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !upd_rise && !start_fall && live_cnt != '0)
      |=> (live_cnt == CNT_W'($past(live_cnt) - 1'b1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !upd_rise) |=> $stable(live_cnt));

  // R5
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall |=> !run_q);

endmodule

bind cdtc_channel cdtc_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .live_cnt     (live_cnt),
  .cnt_buf_q    (cnt_buf_q),
  .expire_pulse (expire_pulse),
  .start_clr_req(start_clr_req),
  .run_q        (run_w),
  .upd_rise     (upd_rise_w),
  .start_fall   (start_fall_w),
  .ar           (ar_w)
);

// File: tb/cdtc_channel_tb_top.sv
module cdtc_channel_tb_top;

  localparam int CW = 16;
  localparam int KW = 32;
  localparam int A_ST = 8, A_UP = 9, A_AR = 11;
  localparam logic [KW-1:0] ST = 32'h1 << A_ST;
  localparam logic [KW-1:0] UP = 32'h1 << A_UP;
  localparam logic [KW-1:0] AR = 32'h1 << A_AR;
  localparam logic [KW-1:0] B_ST = 32'h1 << 20;
  localparam logic [KW-1:0] B_UP = 32'h1 << 21;
  localparam logic [KW-1:0] B_AR = 32'h1 << 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          tick = 1'b0;
  logic [KW-1:0] ctrl_a = '0, ctrl_b = '0;
  logic          we_a = 1'b0, sel_a = 1'b0, we_b = 1'b0, sel_b = 1'b0;
  logic [CW-1:0] d_a = '0, d_b = '0;
  logic [CW-1:0] live_a, cbuf_a, cmp_a, live_b, cbuf_b, cmp_b;
  logic          exp_a, clr_a, exp_b, clr_b;

  cdtc_channel #(.CNT_W(CW), .CTRL_W(KW), .NUM_CHAN(5), .CHAN_IDX(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .ctrl_word(ctrl_a),
    .buf_we(we_a), .buf_sel(sel_a), .buf_wdata(d_a),
    .live_cnt(live_a), .cnt_buf_q(cbuf_a), .cmp_buf_q(cmp_a),
    .expire_pulse(exp_a), .start_clr_req(clr_a));

  cdtc_channel #(.CNT_W(CW), .CTRL_W(KW), .NUM_CHAN(5), .CHAN_IDX(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .ctrl_word(ctrl_b),
    .buf_we(we_b), .buf_sel(sel_b), .buf_wdata(d_b),
    .live_cnt(live_b), .cnt_buf_q(cbuf_b), .cmp_buf_q(cmp_b),
    .expire_pulse(exp_b), .start_clr_req(clr_b));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model of channel A.
  logic [CW-1:0] m_live = '0, m_cbuf = '0, m_cmp = '0;
  bit m_run = 0, m_pst = 0, m_pup = 0, m_exp = 0, m_clr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string pick(input string tag, input string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  // One cycle of channel A: check state, drive, check combinational outputs, advance model.
  task automatic cyc(input string tag, input logic [KW-1:0] c, input bit t,
                     input bit we, input bit sel, input logic [CW-1:0] d);
    bit st, up, ar, ur, sr, sf, nr;
    logic [CW-1:0] nl;
    @(negedge clk);
    chk(pick(tag, "R4"), live_a, m_live);
    chk(pick(tag, "R2"), cbuf_a, m_cbuf);
    chk(pick(tag, "R2"), cmp_a, m_cmp);
    ctrl_a = c; tick = t; we_a = we; sel_a = sel; d_a = d;
    st = c[A_ST]; up = c[A_UP]; ar = c[A_AR];
    ur = up & !m_pup; sr = st & !m_pst; sf = !st & m_pst;
    m_exp = m_run && t && !ur && !sf && (m_live == 0);
    m_clr = m_exp && !ar;
    #1;
    chk(pick(tag, "R6"), exp_a, m_exp);
    chk(pick(tag, "R8"), clr_a, m_clr);
    nl = m_live; nr = m_run;
    if (ur) nl = m_cbuf;
    else if (m_run && t && !sf) begin
      if (m_live == 0) begin
        if (ar) nl = m_cbuf; else nr = 0;
      end else nl = m_live - 1'b1;
    end
    if (sf) nr = 0; else if (sr) nr = 1;
    m_live = nl; m_run = nr;
    if (we && !sel) m_cbuf = d;
    if (we && sel) m_cmp = d;
    m_pst = st; m_pup = up;
  endtask

  task automatic b_step(input logic [KW-1:0] c, input bit t, input bit we,
                        input bit sel, input logic [CW-1:0] d);
    @(negedge clk);
    ctrl_b = c; tick = t; we_b = we; sel_b = sel; d_b = d;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] rc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", live_a, 0); chk("R1", cbuf_a, 0); chk("R1", cmp_a, 0);
    chk("R1", exp_a, 0); chk("R1", clr_a, 0); chk("R1", live_b, 0);

    // R2 buffer writes leave the live count alone
    cyc("R2", 0, 1, 1, 0, 5);
    cyc("R2", 0, 1, 1, 1, 7);
    cyc("R2", 0, 1, 0, 0, 0);
    // R3 update edge loads once; holding high does not reload
    cyc("R3", UP, 0, 0, 0, 0);
    cyc("R3", UP, 0, 1, 0, 3);
    cyc("R3", UP, 1, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0);
    // R9 update and start together: count from loaded value
    cyc("R9", UP | ST | AR, 1, 0, 0, 0);
    cyc("R9", UP | ST | AR, 1, 0, 0, 0);
    cyc("R4", UP | ST | AR, 1, 0, 0, 0);
    // R12 update edge wins over a tick at zero
    cyc("R12", ST | AR, 1, 1, 0, 6);
    cyc("R12", UP | ST | AR, 1, 0, 0, 0);
    repeat (6) cyc("R4", ST | AR, 1, 0, 0, 0);
    // R7 expiry with reload
    cyc("R7", ST | AR, 1, 0, 0, 0);
    cyc("R7", ST | AR, 0, 0, 0, 0);
    // R5 halt edge with tick
    cyc("R5", AR, 1, 0, 0, 0);
    cyc("R5", AR, 1, 0, 0, 0);
    cyc("R5", AR, 1, 0, 0, 0);
    // R8 one-shot: stops and requests start clear
    cyc("R8", UP | AR, 0, 1, 0, 2);
    cyc("R8", ST, 0, 0, 0, 0);
    repeat (6) cyc("R8", ST, 1, 0, 0, 0);
    cyc("R8", ST, 1, 0, 0, 0);
    cyc("R8", 0, 1, 0, 0, 0);
    cyc("R8", 0, 1, 0, 0, 0);

    // Random phase, R10: unrelated control bits churn freely
    void'($urandom(32'h5EED_0042));
    rc = '0;
    for (int i = 0; i < 3000; i++) begin
      logic [KW-1:0] c;
      c = $urandom;
      c[A_ST] = rc[A_ST]; c[A_UP] = rc[A_UP]; c[A_AR] = rc[A_AR];
      if ($urandom % 8 == 0) c[A_ST] = ~c[A_ST];
      if ($urandom % 6 == 0) c[A_UP] = ~c[A_UP];
      if ($urandom % 10 == 0) c[A_AR] = ~c[A_AR];
      if (m_clr) c[A_ST] = 1'b0;
      rc = c;
      cyc("", c, bit'($urandom % 2), bit'($urandom % 5 == 0), bit'($urandom % 2),
          CW'($urandom % 6));
    end
    cyc("RND", rc & ~ST, 0, 0, 0, 0);

    // Last channel position: bits 20/21/22, no compare buffer
    b_step(0, 0, 1, 1, 9);
    b_step(0, 0, 1, 0, 2);
    chk("R11", cmp_b, 0);
    b_step(ST | UP | AR, 0, 0, 0, 0);
    chk("R2", cbuf_b, 2);
    b_step(B_UP, 0, 0, 0, 0);
    chk("R10", live_b, 0);
    b_step(B_UP | B_ST | B_AR, 0, 0, 0, 0);
    chk("R10", live_b, 2);
    b_step(B_UP | B_ST | B_AR, 1, 0, 0, 0);
    chk("R10", exp_b, 0);
    b_step(B_UP | B_ST | B_AR, 1, 0, 0, 0);
    chk("R10", live_b, 1);
    b_step(B_UP | B_ST | B_AR, 1, 0, 0, 0);
    chk("R7", exp_b, 1); chk("R7", clr_b, 0);
    b_step(B_ST, 1, 0, 0, 0);
    chk("R7", live_b, 2);
    b_step(B_ST, 1, 0, 0, 0);
    b_step(B_ST, 1, 0, 0, 0);
    chk("R10", exp_b, 1); chk("R10", clr_b, 1);
    b_step(B_ST, 1, 0, 0, 0);
    chk("R8", live_b, 0); chk("R8", exp_b, 0);
    chk("R11", cmp_b, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule